// File: doc/BRIEF.md
# Bootstrap Replenish Hiccup Controller

This block supervises the boot capacitor of a high-side gate driver once per switching cycle. A single-clock switching tick marks each cycle; on that tick the controller samples a boot-undervoltage flag. While the flag is set, it asks the low-side driver for a short forced-on pulse that recharges the boot capacitor. It allows only a short burst of such cycles back to back, and then inhibits switching for a gap. If several bursts in a row leave the flag still set, it stops switching for a long off-time. During that off-time it holds power-good low and discharges soft-start.

The pulse width is a whole number of clocks. It is derived from a pulse duration in nanoseconds and the clock frequency in MHz, rounded up. With the defaults (50 MHz, 75 ns) the pulse is 4 clocks. All tick counts are parameters: burst length 4, skip gap 12, set limit 4 and hiccup off-time 512.

The controller is a four-state machine:
- `ST_RUN` is normal switching.
- `ST_RECHARGE` is a burst of forced pulses.
- `ST_SKIP` is the gap after a full burst.
- `ST_HICCUP` is the long off-time.

Transitions happen only on a tick:
- RUN→RECHARGE when the flag is set.
- RECHARGE→RECHARGE on the next pulse of the burst.
- RECHARGE→SKIP on the tick after a full burst, while fewer than the set limit of bursts have run.
- RECHARGE→HICCUP on the tick after the last allowed burst.
- SKIP→SKIP while the gap counts.
- SKIP→RECHARGE when the gap has elapsed.
- RECHARGE→RUN or SKIP→RUN when the flag is clear.
- HICCUP→RUN when the off-time has elapsed.

Top module: `boot_recharge_ctrl`

## Requirements
- R1: A forced pulse starts only on a tick that samples `boot_uv` high in ST_RUN or in an unfinished burst. `force_lo` is then high for exactly PULSE_CLKS clocks (4 by default), starting the clock after the tick edge. Without a tick, `boot_uv` causes no pulse.
- R2: No more than BURST_LEN (4) consecutive ticks carry a forced pulse.
- R3: The tick after a full burst, with `boot_uv` still high, starts a skip gap of SKIP_TICKS (12) ticks, counting that tick. Each of those ticks has `sw_inhibit` high and no pulse. The tick after the gap, with `boot_uv` high, starts a new burst and releases `sw_inhibit`.
- R4: After MAX_SETS (4) full bursts without recovery, the tick after the last burst enters the hiccup off-time rather than a skip gap. Exactly 16 pulses precede it by default.
- R5: The hiccup off-time lasts HICCUP_TICKS (512) ticks, counting the entry tick. Throughout it `pgood_low`, `ss_discharge` and `sw_inhibit` are high and no pulse is issued. `boot_uv` is ignored.
- R6: A tick that samples `boot_uv` low outside the off-time returns to ST_RUN. It clears the burst, set and gap counts and releases `sw_inhibit` at once.
- R7: The tick after the off-time returns to ST_RUN with all counts cleared and all outputs released. A later flagged tick starts a fresh burst.
- R8: During and right after reset, every output is low and the state is ST_RUN.
- R9: `sw_inhibit` is high only in ST_SKIP and ST_HICCUP. `pgood_low` and `ss_discharge` are high only in ST_HICCUP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_tick | input | 1 | One-clock strobe at each switching cycle |
| boot_uv | input | 1 | Boot capacitor undervoltage flag, sampled on the tick |
| force_lo | output | 1 | Forced low-side on request |
| sw_inhibit | output | 1 | Suppress normal switching |
| pgood_low | output | 1 | Force power-good low |
| ss_discharge | output | 1 | Discharge the soft-start capacitor |

## Verification
The most delicate tick is the one that ends a skip gap. On that single tick the controller must release `sw_inhibit` and also start a new forced pulse; if `boot_uv` has cleared on that same tick, it must instead return to normal with every count cleared. The bench drives the flag high through whole skip gaps, then low exactly at gap boundaries and inside a gap. It compares the pulse and inhibit outputs one clock after each tick against a tick-indexed model of the burst, skip and hiccup pattern. The bench also requires a full 52-tick run after a mid-gap clear before hiccup begins, which shows the set count was reset.

// File: rtl/bhc_pkg.sv
package bhc_pkg;

    typedef enum logic [1:0] {
        ST_RUN      = 2'd0,
        ST_RECHARGE = 2'd1,
        ST_SKIP     = 2'd2,
        ST_HICCUP   = 2'd3
    } bhc_state_e;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/bhc_counter.sv
module bhc_counter #(
    parameter int MAXV = 4,
    parameter int W    = $clog2(MAXV + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         start,
    input  logic         inc,
    output logic [W-1:0] count
);

    localparam logic [W-1:0] TOP = W'(MAXV);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (start) begin
            count <= W'(1);
        end else if (inc && (count != TOP)) begin
            count <= count + W'(1);
        end
    end

endmodule

// File: rtl/bhc_pulse_timer.sv
module bhc_pulse_timer #(
    parameter int PULSE_CLKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic pulse
);

    localparam int PW = $clog2(PULSE_CLKS + 1);
    localparam logic [PW-1:0] LOAD = PW'(PULSE_CLKS);

    logic [PW-1:0] remain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (start) begin
            remain_q <= LOAD;
        end else if (remain_q != '0) begin
            remain_q <= remain_q - PW'(1);
        end
    end

    assign pulse = (remain_q != '0);

    AST_PULSE_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (remain_q != '0 && !start) |=> (remain_q == PW'($past(remain_q) - PW'(1)))); // R1

    AST_PULSE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (remain_q == LOAD)); // R1

endmodule

// File: rtl/boot_recharge_ctrl.sv
module boot_recharge_ctrl
    import bhc_pkg::*;
#(
    parameter int CLK_MHZ      = 50,
    parameter int PULSE_NS     = 75,
    parameter int BURST_LEN    = 4,
    parameter int SKIP_TICKS   = 12,
    parameter int MAX_SETS     = 4,
    parameter int HICCUP_TICKS = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_tick,
    input  logic boot_uv,
    output logic force_lo,
    output logic sw_inhibit,
    output logic pgood_low,
    output logic ss_discharge
);

    localparam int PULSE_RAW  = ceil_div(PULSE_NS * CLK_MHZ, 1000);
    localparam int PULSE_CLKS = max_int(PULSE_RAW, 1);
    localparam int GAP_MAX    = max_int(SKIP_TICKS, HICCUP_TICKS);
    localparam int BW         = $clog2(BURST_LEN + 1);
    localparam int SW         = $clog2(MAX_SETS + 1);
    localparam int GW         = $clog2(GAP_MAX + 1);

    localparam logic [BW-1:0] BURST_FULL = BW'(BURST_LEN);
    localparam logic [SW-1:0] SET_LAST   = SW'(MAX_SETS - 1);
    localparam logic [GW-1:0] SKIP_END   = GW'(SKIP_TICKS);
    localparam logic [GW-1:0] HIC_END    = GW'(HICCUP_TICKS);

    bhc_state_e    state_q, state_d;
    logic [BW-1:0] burst_cnt;
    logic [SW-1:0] set_cnt;
    logic [GW-1:0] gap_cnt;

    logic b_clr, b_start, b_inc;
    logic s_clr, s_inc;
    logic g_clr, g_start, g_inc;
    logic fire;

    // Consecutive forced-pulse ticks within the current burst
    bhc_counter #(.MAXV(BURST_LEN), .W(BW)) u_burst (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (b_clr),
        .start (b_start),
        .inc   (b_inc),
        .count (burst_cnt)
    );

    // Completed bursts since the flag last cleared
    bhc_counter #(.MAXV(MAX_SETS), .W(SW)) u_sets (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (s_clr),
        .start (1'b0),
        .inc   (s_inc),
        .count (set_cnt)
    );

    // Ticks spent in the skip gap or the hiccup off-time
    bhc_counter #(.MAXV(GAP_MAX), .W(GW)) u_gap (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (g_clr),
        .start (g_start),
        .inc   (g_inc),
        .count (gap_cnt)
    );

    bhc_pulse_timer #(.PULSE_CLKS(PULSE_CLKS)) u_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .start (fire),
        .pulse (force_lo)
    );

    // Next-state and counter control, evaluated only on a tick
    always_comb begin
        state_d = state_q;
        b_clr   = 1'b0;
        b_start = 1'b0;
        b_inc   = 1'b0;
        s_clr   = 1'b0;
        s_inc   = 1'b0;
        g_clr   = 1'b0;
        g_start = 1'b0;
        g_inc   = 1'b0;
        fire    = 1'b0;
        if (cyc_tick) begin
            unique case (state_q)
                ST_RUN: begin
                    if (boot_uv) begin
                        fire    = 1'b1;
                        b_start = 1'b1;
                        state_d = ST_RECHARGE;
                    end
                end
                ST_RECHARGE: begin
                    if (!boot_uv) begin
                        b_clr   = 1'b1;
                        s_clr   = 1'b1;
                        g_clr   = 1'b1;
                        state_d = ST_RUN;
                    end else if (burst_cnt != BURST_FULL) begin
                        fire  = 1'b1;
                        b_inc = 1'b1;
                    end else if (set_cnt == SET_LAST) begin
                        b_clr   = 1'b1;
                        s_clr   = 1'b1;
                        g_start = 1'b1;
                        state_d = ST_HICCUP;
                    end else begin
                        b_clr   = 1'b1;
                        s_inc   = 1'b1;
                        g_start = 1'b1;
                        state_d = ST_SKIP;
                    end
                end
                ST_SKIP: begin
                    if (!boot_uv) begin
                        b_clr   = 1'b1;
                        s_clr   = 1'b1;
                        g_clr   = 1'b1;
                        state_d = ST_RUN;
                    end else if (gap_cnt == SKIP_END) begin
                        fire    = 1'b1;
                        b_start = 1'b1;
                        g_clr   = 1'b1;
                        state_d = ST_RECHARGE;
                    end else begin
                        g_inc = 1'b1;
                    end
                end
                ST_HICCUP: begin
                    if (gap_cnt == HIC_END) begin
                        b_clr   = 1'b1;
                        s_clr   = 1'b1;
                        g_clr   = 1'b1;
                        state_d = ST_RUN;
                    end else begin
                        g_inc = 1'b1;
                    end
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs decoded from the registered state
    always_comb begin
        sw_inhibit   = 1'b0;
        pgood_low    = 1'b0;
        ss_discharge = 1'b0;
        unique case (state_q)
            ST_RUN:      sw_inhibit = 1'b0;
            ST_RECHARGE: sw_inhibit = 1'b0;
            ST_SKIP:     sw_inhibit = 1'b1;
            ST_HICCUP: begin
                sw_inhibit   = 1'b1;
                pgood_low    = 1'b1;
                ss_discharge = 1'b1;
            end
        endcase
    end

    AST_PULSE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(force_lo) |-> $past(cyc_tick && boot_uv)); // R1

    AST_BURST_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        burst_cnt <= BURST_FULL); // R2

    AST_SET_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        set_cnt <= SET_LAST); // R4

    AST_HICCUP_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(force_lo) |-> !ss_discharge); // R5

    AST_UV_CLEAR_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_tick && !boot_uv && !ss_discharge) |=> (burst_cnt == '0 && set_cnt == '0 && !sw_inhibit)); // R6

    AST_HICCUP_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ss_discharge) |-> $past(cyc_tick && gap_cnt == HIC_END)); // R7

    AST_SS_IMPLIES_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
        ss_discharge |-> (sw_inhibit && pgood_low)); // R9

endmodule

// File: tb/boot_recharge_ctrl_bench.sv
`timescale 1ns/1ps
module boot_recharge_ctrl_bench;

    localparam int TICK_GAP   = 7;
    localparam int PULSE_EXP  = 4;
    localparam int BURST      = 4;
    localparam int SKIP       = 12;
    localparam int SETS       = 4;
    localparam int HIC        = 512;
    localparam int SPAN       = BURST + SKIP;
    localparam int HIC_START  = SETS * SPAN - SKIP;
    localparam int HIC_STOP   = HIC_START + HIC;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cyc_tick = 1'b0;
    logic boot_uv = 1'b0;
    logic force_lo, sw_inhibit, pgood_low, ss_discharge;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    boot_recharge_ctrl u_boot_recharge_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cyc_tick     (cyc_tick),
        .boot_uv      (boot_uv),
        .force_lo     (force_lo),
        .sw_inhibit   (sw_inhibit),
        .pgood_low    (pgood_low),
        .ss_discharge (ss_discharge)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One switching cycle: tick with a flag value, then observe TICK_GAP clocks
    task automatic step(input logic uv, output int pw, output logic inh,
                        output logic pg, output logic ss);
        boot_uv  = uv;
        cyc_tick = 1'b1;
        @(negedge clk);
        cyc_tick = 1'b0;
        inh = sw_inhibit;
        pg  = pgood_low;
        ss  = ss_discharge;
        pw  = 0;
        for (int i = 0; i < TICK_GAP; i++) begin
            if (force_lo) pw++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R8 reset force_lo", int'(force_lo), 0);
        chk("R8 reset sw_inhibit", int'(sw_inhibit), 0);
        chk("R8 reset pgood_low", int'(pgood_low), 0);
        chk("R8 reset ss_discharge", int'(ss_discharge), 0);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R8 after reset outputs", int'({force_lo, sw_inhibit, pgood_low, ss_discharge}), 0);
    endtask

    task automatic t_no_tick();
        int highs = 0;
        boot_uv = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (force_lo) highs++;
        end
        boot_uv = 1'b0;
        chk("R1 flag without tick gives no pulse", highs, 0);
    endtask

    task automatic t_short_fault();
        int pw; logic inh, pg, ss;
        step(1'b1, pw, inh, pg, ss);
        chk("R1 pulse width first", pw, PULSE_EXP);
        chk("R9 no inhibit in burst", int'(inh), 0);
        step(1'b1, pw, inh, pg, ss);
        chk("R1 pulse width second", pw, PULSE_EXP);
        step(1'b0, pw, inh, pg, ss);
        chk("R6 clear tick no pulse", pw, 0);
        chk("R6 clear tick no inhibit", int'(inh), 0);
        step(1'b0, pw, inh, pg, ss);
        chk("R9 idle no pulse", pw, 0);
    endtask

    task automatic t_burst_skip();
        int pw; logic inh, pg, ss;
        for (int i = 0; i < BURST; i++) begin
            step(1'b1, pw, inh, pg, ss);
            chk("R2 burst pulse", pw, PULSE_EXP);
        end
        for (int i = 0; i < SKIP; i++) begin
            step(1'b1, pw, inh, pg, ss);
            chk("R3 skip no pulse", pw, 0);
            chk("R3 skip inhibit", int'(inh), 1);
            chk("R9 skip keeps pgood", int'(pg), 0);
        end
        step(1'b1, pw, inh, pg, ss);
        chk("R3 gap end restarts burst", pw, PULSE_EXP);
        chk("R3 gap end releases inhibit", int'(inh), 0);
        step(1'b0, pw, inh, pg, ss);
        chk("R6 clear after burst", int'(inh), 0);
    endtask

    // Tick-indexed model of the full fault sequence from a clean start
    task automatic run_sequence(input int first, input int count, input int off_lo, input int off_hi);
        int pw; logic inh, pg, ss;
        int pulses = 0;
        for (int i = first; i < first + count; i++) begin
            bit in_sets = (i < HIC_START);
            bit exp_pulse = (in_sets && (i % SPAN) < BURST) || (i > HIC_STOP);
            bit exp_hic = (i >= HIC_START) && (i < HIC_STOP);
            bit exp_inh = (in_sets && (i % SPAN) >= BURST) || exp_hic;
            logic uv = !(i >= off_lo && i < off_hi);
            step(uv, pw, inh, pg, ss);
            if (pw != 0 && i < HIC_START) pulses++;
            if (i == HIC_STOP) begin
                chk("R7 exit no pulse", pw, 0);
                chk("R7 exit inhibit released", int'(inh), 0);
                chk("R7 exit ss released", int'(ss), 0);
                chk("R7 exit pgood released", int'(pg), 0);
            end else if (i > HIC_STOP) begin
                chk("R7 fresh burst pulse", pw, PULSE_EXP);
                chk("R7 fresh burst no inhibit", int'(inh), 0);
            end else if (exp_hic) begin
                chk((i == HIC_START) ? "R4 hiccup entry ss" : "R5 hiccup ss", int'(ss), 1);
                chk("R5 hiccup pgood low", int'(pg), 1);
                chk("R5 hiccup inhibit", int'(inh), 1);
                chk("R5 hiccup no pulse", pw, 0);
            end else begin
                chk(exp_pulse ? "R2 set pulse" : "R3 set gap no pulse", pw, exp_pulse ? PULSE_EXP : 0);
                chk("R3 set inhibit", int'(inh), int'(exp_inh));
                chk("R9 no ss before hiccup", int'(ss), 0);
            end
        end
        if (first == 0 && first + count > HIC_START)
            chk("R4 pulses before hiccup", pulses, SETS * BURST);
    endtask

    task automatic t_clear_mid_skip();
        int pw; logic inh, pg, ss;
        run_sequence(0, 40, -1, -1);
        step(1'b0, pw, inh, pg, ss);
        chk("R6 mid-skip clear releases inhibit", int'(inh), 0);
        chk("R6 mid-skip clear no pulse", pw, 0);
    endtask

    task automatic t_full_hiccup();
        int pw; logic inh, pg, ss;
        run_sequence(0, HIC_STOP + 2, 100, HIC_STOP);
        step(1'b0, pw, inh, pg, ss);
        chk("R6 final clear", int'(inh), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_no_tick();
        t_short_fault();
        t_burst_skip();
        t_clear_mid_skip();
        t_full_hiccup();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule